// File: doc/BRIEF.md
# Dual-window video bank address translator

This block sits between the CPU's legacy 128 KB video aperture and a much larger video memory. Software programs a small set of configuration registers through a byte-wide register port: two 16-bit bank bases (primary and secondary), a banking control byte, an aperture control byte, a chain-4 control byte and a frame-buffer-only control byte. From these registers the block builds two four-entry bank tables, one for reads and one for writes. Each entry gives the video memory base of one 32 KB slot of the aperture.

For each CPU access, the block selects the slot from the aperture address and adds the masked offset to that slot's base. It then truncates the sum to the decode width and raises a reject flag when the result lies beyond the installed memory. In that case the memory controller drops a write, or returns all ones for a read at the access width.

When frame-buffer-only operation is off, no direct address is produced. Instead, the selected slot base is handed to the planar VGA path. The block also exports the packed chain-4 and chain-4 flags. It raises a sticky error flag when software selects a banking mode that the block does not support.

Top module: `bank_xlate_top`

## Requirements
- R1: After reset every configuration register reads as zero. So fb_only_o, chain4_o, packed_chain4_o and mode_err_o are 0, and for a read of slot s, planar_base_o equals s*0x8000.
- R2: The primary base is {reg 0x18, reg 0x19} shifted left by 6 bits. When reg 0x1E bit 4 is set and bit 2 is clear, slot s of both tables maps to primary + s*0x8000.
- R3: With reg 0x1E bit 4 clear, slot s of both tables maps to s*0x8000, whatever the other bits of reg 0x1E and the base registers hold.
- R4: The secondary base is {reg 0x1C, reg 0x1D} shifted left by 6 bits. With reg 0x1E bits 4 and 2 both set and mode field reg 0x1E[7:5] = 0, slot s maps writes to primary + s*0x8000 and reads to secondary + s*0x8000.
- R5: Mode 2 maps slots 0 and 1 to primary + 0 and primary + 0x8000, and slots 2 and 3 to secondary + 0 and secondary + 0x8000. Reads and writes use the same mapping.
- R6: Mode 3 maps slot s to secondary + s*0x8000 for both reads and writes.
- R7: Mode 6 maps slots 0 to 3 to primary, secondary, primary + 0x8000 and secondary + 0x8000, for both reads and writes.
- R8: When both enable bits are set and the mode field is 1, 4, 5 or 7, both tables fall back to the R2 primary-only mapping. mode_err_o goes to 1 one cycle after that configuration takes effect and stays at 1 until reset.
- R9: The slot index is acc_addr_i[16:15]. The offset is acc_addr_i[16:0] when reg 0x20 bit 0 is set, otherwise acc_addr_i[15:0]. mem_addr_o is (offset + slot base) modulo 2^ADDR_W, using the write table when acc_write_i is 1 and the read table otherwise.
- R10: With frame-buffer-only set, reject_o is 1 exactly when the translated address is at or above VRAM_BYTES. Addresses that wrap past 2^ADDR_W are truncated before this compare.
- R11: fb_only_o is reg 0x21 bit 0. While it is 0, mem_addr_o and reject_o are 0 and planar_base_o carries the selected slot base. While it is 1, planar_base_o is 0.
- R12: packed_chain4_o is reg 0x20 bit 1, and chain4_o is reg 0x04 bit 3 OR packed_chain4_o.
- R13: A register write takes effect from the cycle after its write strobe. An access in the same cycle as the write sees the old tables and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Configuration register write strobe |
| reg_idx_i | input | 8 | Configuration register index |
| reg_wdata_i | input | 8 | Configuration register write data |
| acc_addr_i | input | 17 | CPU offset within the 128 KB aperture |
| acc_write_i | input | 1 | 1 for a write access, 0 for a read |
| mem_addr_o | output | ADDR_W | Translated video memory address |
| reject_o | output | 1 | Translated address beyond installed memory |
| planar_base_o | output | 23 | Selected slot base for the planar path |
| fb_only_o | output | 1 | Frame-buffer-only operation |
| chain4_o | output | 1 | Chain-4 addressing active |
| packed_chain4_o | output | 1 | Packed chain-4 mode |
| mode_err_o | output | 1 | Sticky unsupported banking mode flag |

## Verification
The bench walks all four slots of every supported mode for both reads and writes. A design that copied the read table into the write table in mode 0, or that swapped the interleave order of mode 6, would return the wrong base for at least one slot. It sets the base to its maximum so that the sum wraps past the decode width: a design that compared before truncating would reject the wrapped slot, and one that never rejected would pass the top of memory. It writes a register and accesses the aperture in the same cycle, which catches a design whose tables follow the write data too early. It also checks that the error flag survives a later move back to a supported mode.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;
  localparam int unsigned NUM_SLOTS  = 4;
  localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS);
  localparam int unsigned BANK_REG_W = 16;
  localparam int unsigned BANK_SHIFT = 6;
  localparam int unsigned BASE_W     = BANK_REG_W + BANK_SHIFT + 1;
  localparam int unsigned SLOT_SPAN  = 32'h8000;
  localparam int unsigned APER_W     = 17;

  localparam logic [7:0] IDX_CHAIN   = 8'h04;
  localparam logic [7:0] IDX_PRIM_HI = 8'h18;
  localparam logic [7:0] IDX_PRIM_LO = 8'h19;
  localparam logic [7:0] IDX_SEC_HI  = 8'h1C;
  localparam logic [7:0] IDX_SEC_LO  = 8'h1D;
  localparam logic [7:0] IDX_BANKCTL = 8'h1E;
  localparam logic [7:0] IDX_APERCTL = 8'h20;
  localparam logic [7:0] IDX_FBCTL   = 8'h21;

  localparam logic [2:0] MAP_SPLIT      = 3'd0;
  localparam logic [2:0] MAP_HALVES     = 3'd2;
  localparam logic [2:0] MAP_SECONDARY  = 3'd3;
  localparam logic [2:0] MAP_INTERLEAVE = 3'd6;

  typedef logic [BASE_W-1:0] base_t;

  typedef struct packed {
    logic [BANK_REG_W-1:0] prim;
    logic [BANK_REG_W-1:0] sec;
    logic                  ext_en;
    logic                  dual_en;
    logic [2:0]            mode;
    logic                  wide_off;
    logic                  packed_c4;
    logic                  chain4;
    logic                  fb_only;
  } bank_cfg_t;
endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
  import bank_xlate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_idx_i,
  input  logic [7:0] reg_wdata_i,
  output bank_cfg_t  cfg_o,
  output logic       mode_err_o
);
  logic [7:0] chain_q, prim_hi_q, prim_lo_q, sec_hi_q, sec_lo_q;
  logic [7:0] bankctl_q, aperctl_q, fbctl_q;
  logic       err_q, unsupported;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q   <= '0;
      prim_hi_q <= '0;
      prim_lo_q <= '0;
      sec_hi_q  <= '0;
      sec_lo_q  <= '0;
      bankctl_q <= '0;
      aperctl_q <= '0;
      fbctl_q   <= '0;
    end else if (reg_we_i) begin
      case (reg_idx_i)
        IDX_CHAIN:   chain_q   <= reg_wdata_i;
        IDX_PRIM_HI: prim_hi_q <= reg_wdata_i;
        IDX_PRIM_LO: prim_lo_q <= reg_wdata_i;
        IDX_SEC_HI:  sec_hi_q  <= reg_wdata_i;
        IDX_SEC_LO:  sec_lo_q  <= reg_wdata_i;
        IDX_BANKCTL: bankctl_q <= reg_wdata_i;
        IDX_APERCTL: aperctl_q <= reg_wdata_i;
        IDX_FBCTL:   fbctl_q   <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_o.prim      = {prim_hi_q, prim_lo_q};
    cfg_o.sec       = {sec_hi_q, sec_lo_q};
    cfg_o.ext_en    = bankctl_q[4];
    cfg_o.dual_en   = bankctl_q[2];
    cfg_o.mode      = bankctl_q[7:5];
    cfg_o.wide_off  = aperctl_q[0];
    cfg_o.packed_c4 = aperctl_q[1];
    cfg_o.chain4    = chain_q[3] | aperctl_q[1];
    cfg_o.fb_only   = fbctl_q[0];
  end

  assign unsupported = cfg_o.ext_en && cfg_o.dual_en &&
    !(cfg_o.mode inside {MAP_SPLIT, MAP_HALVES, MAP_SECONDARY, MAP_INTERLEAVE});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | unsupported;
  end

  assign mode_err_o = err_q;
endmodule

// File: rtl/bank_table_gen.sv
module bank_table_gen
  import bank_xlate_pkg::*;
(
  input  bank_cfg_t                cfg_i,
  output base_t [NUM_SLOTS-1:0]    rd_tbl_o,
  output base_t [NUM_SLOTS-1:0]    wr_tbl_o
);
  base_t prim_b, sec_b;
  logic  split;

  assign prim_b = base_t'({cfg_i.prim, {BANK_SHIFT{1'b0}}});
  assign sec_b  = base_t'({cfg_i.sec, {BANK_SHIFT{1'b0}}});
  assign split  = cfg_i.ext_en && cfg_i.dual_en && (cfg_i.mode == MAP_SPLIT);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam base_t CONS_OFS = base_t'(s * SLOT_SPAN);
    localparam base_t LOW_OFS  = base_t'((s % 2) * SLOT_SPAN);
    localparam base_t PAIR_OFS = base_t'((s / 2) * SLOT_SPAN);
    localparam bit    ODD      = (s % 2) == 1;
    localparam bit    LOWER    = s < 2;
    base_t rd_b;

    always_comb begin
      rd_b = prim_b + CONS_OFS;
      if (!cfg_i.ext_en) begin
        rd_b = CONS_OFS;
      end else if (cfg_i.dual_en) begin
        case (cfg_i.mode)
          MAP_SPLIT, MAP_SECONDARY: rd_b = sec_b + CONS_OFS;
          MAP_HALVES:     rd_b = (LOWER ? prim_b : sec_b) + LOW_OFS;
          MAP_INTERLEAVE: rd_b = (ODD ? sec_b : prim_b) + PAIR_OFS;
          default:        rd_b = prim_b + CONS_OFS;
        endcase
      end
    end

    assign rd_tbl_o[s] = rd_b;
    assign wr_tbl_o[s] = split ? (prim_b + CONS_OFS) : rd_b;
  end
endmodule

// File: rtl/bank_addr_xlate.sv
module bank_addr_xlate
  import bank_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned VRAM_BYTES = 32'h0020_0000
) (
  input  logic [APER_W-1:0]     acc_addr_i,
  input  logic                  acc_write_i,
  input  base_t [NUM_SLOTS-1:0] rd_tbl_i,
  input  base_t [NUM_SLOTS-1:0] wr_tbl_i,
  input  logic                  wide_off_i,
  input  logic                  fb_only_i,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic                  reject_o,
  output base_t                 planar_base_o
);
  localparam int unsigned SUM_W = BASE_W + 1;
  localparam logic [ADDR_W:0] VRAM_LIM = (ADDR_W + 1)'(VRAM_BYTES);

  logic [SLOT_W-1:0] slot;
  base_t             base;
  logic [SUM_W-1:0]  offset, sum;
  logic [ADDR_W-1:0] xlat;

  assign slot   = acc_addr_i[APER_W-1 -: SLOT_W];
  assign base   = acc_write_i ? wr_tbl_i[slot] : rd_tbl_i[slot];
  assign offset = wide_off_i ? SUM_W'(acc_addr_i) : SUM_W'(acc_addr_i[APER_W-2:0]);
  assign sum    = SUM_W'(base) + offset;
  assign xlat   = sum[ADDR_W-1:0];

  assign mem_addr_o    = fb_only_i ? xlat : '0;
  assign reject_o      = fb_only_i && ({1'b0, xlat} >= VRAM_LIM);
  assign planar_base_o = fb_only_i ? '0 : base;
endmodule

// File: rtl/bank_xlate_top.sv
module bank_xlate_top
  import bank_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned VRAM_BYTES = 32'h0020_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_idx_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic [16:0]       acc_addr_i,
  input  logic              acc_write_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              reject_o,
  output logic [22:0]       planar_base_o,
  output logic              fb_only_o,
  output logic              chain4_o,
  output logic              packed_chain4_o,
  output logic              mode_err_o
);
  bank_cfg_t             cfg;
  base_t [NUM_SLOTS-1:0] rd_tbl, wr_tbl;

  bank_cfg_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_idx_i   (reg_idx_i),
    .reg_wdata_i (reg_wdata_i),
    .cfg_o       (cfg),
    .mode_err_o  (mode_err_o)
  );

  bank_table_gen u_tables (
    .cfg_i    (cfg),
    .rd_tbl_o (rd_tbl),
    .wr_tbl_o (wr_tbl)
  );

  bank_addr_xlate #(
    .ADDR_W     (ADDR_W),
    .VRAM_BYTES (VRAM_BYTES)
  ) u_xlate (
    .acc_addr_i    (acc_addr_i),
    .acc_write_i   (acc_write_i),
    .rd_tbl_i      (rd_tbl),
    .wr_tbl_i      (wr_tbl),
    .wide_off_i    (cfg.wide_off),
    .fb_only_i     (cfg.fb_only),
    .mem_addr_o    (mem_addr_o),
    .reject_o      (reject_o),
    .planar_base_o (planar_base_o)
  );

  assign fb_only_o       = cfg.fb_only;
  assign chain4_o        = cfg.chain4;
  assign packed_chain4_o = cfg.packed_c4;
endmodule

// File: rtl/bank_xlate_checker.sv
module bank_xlate_checker #(
  parameter int unsigned ADDR_W = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [16:0]       acc_addr_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              reject_o,
  input logic [22:0]       planar_base_o,
  input logic              fb_only_o,
  input logic              chain4_o,
  input logic              packed_chain4_o,
  input logic              mode_err_o
);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |=> mode_err_o);

  p_direct_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_only_o |-> (mem_addr_o == '0) && !reject_o);

  p_planar_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_only_o |-> (planar_base_o == '0));

  p_packed_forces_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    packed_chain4_o |-> chain4_o);

  p_low_bits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_only_o |-> (mem_addr_o[5:0] == acc_addr_i[5:0]));

  p_cfg_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_we_i) |-> $stable(fb_only_o) && $stable(chain4_o) && $stable(packed_chain4_o));
endmodule

bind bank_xlate_top bank_xlate_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_we_i        (reg_we_i),
  .acc_addr_i      (acc_addr_i),
  .mem_addr_o      (mem_addr_o),
  .reject_o        (reject_o),
  .planar_base_o   (planar_base_o),
  .fb_only_o       (fb_only_o),
  .chain4_o        (chain4_o),
  .packed_chain4_o (packed_chain4_o),
  .mode_err_o      (mode_err_o)
);

// File: tb/bank_xlate_top_bench.sv
module bank_xlate_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 22;
  localparam longint VRAM   = 64'h20_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [7:0]        reg_idx = '0;
  logic [7:0]        reg_wdata = '0;
  logic [16:0]       acc_addr = '0;
  logic              acc_write = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic              reject;
  logic [22:0]       planar_base;
  logic              fb_only, chain4, packed_c4, mode_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m [0:255];
  bit         m_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bank_xlate_top u_bank_xlate_top (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .reg_we_i        (reg_we),
    .reg_idx_i       (reg_idx),
    .reg_wdata_i     (reg_wdata),
    .acc_addr_i      (acc_addr),
    .acc_write_i     (acc_write),
    .mem_addr_o      (mem_addr),
    .reject_o        (reject),
    .planar_base_o   (planar_base),
    .fb_only_o       (fb_only),
    .chain4_o        (chain4),
    .packed_chain4_o (packed_c4),
    .mode_err_o      (mode_err)
  );

  function automatic bit unsup_mode();
    return m[8'h1E][4] && m[8'h1E][2] && !(m[8'h1E][7:5] inside {3'd0, 3'd2, 3'd3, 3'd6});
  endfunction

  function automatic longint exp_base(bit wr, int s);
    longint prim = longint'({m[8'h18], m[8'h19]}) * 64;
    longint sec  = longint'({m[8'h1C], m[8'h1D]}) * 64;
    longint span = 64'h8000;
    if (!m[8'h1E][4]) return s * span;
    if (!m[8'h1E][2]) return prim + s * span;
    case (m[8'h1E][7:5])
      3'd0: return wr ? prim + s * span : sec + s * span;
      3'd2: return (s < 2) ? prim + s * span : sec + (s - 2) * span;
      3'd3: return sec + s * span;
      3'd6: return ((s % 2) ? sec : prim) + (s / 2) * span;
      default: return prim + s * span;
    endcase
  endfunction

  function automatic logic [49:0] expect_vec(logic [16:0] a, bit wr);
    longint base = exp_base(wr, int'(a[16:15]));
    longint off  = m[8'h20][0] ? longint'(a) : longint'(a[15:0]);
    longint x    = (off + base) % (64'd1 << ADDR_W);
    bit     fb   = m[8'h21][0];
    bit     pc   = m[8'h20][1];
    logic [ADDR_W-1:0] ea = fb ? ADDR_W'(x) : '0;
    logic              er = fb && (x >= VRAM);
    logic [22:0]       ep = fb ? '0 : 23'(base);
    return {ea, er, ep, fb, pc | m[8'h04][3], pc, m_err};
  endfunction

  task automatic step(input bit we, input logic [7:0] idx, input logic [7:0] dat,
                      input logic [16:0] a, input bit wr, input string tag);
    logic [49:0] act, exp_v;
    reg_we = we; reg_idx = idx; reg_wdata = dat; acc_addr = a; acc_write = wr;
    @(negedge clk);
    exp_v = expect_vec(a, wr);
    act = {mem_addr, reject, planar_base, fb_only, chain4, packed_c4, mode_err};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0d actual=%h expected=%h", tag, a, wr, act, exp_v);
    end
    @(posedge clk);
    #1;
    if (unsup_mode()) m_err = 1;
    if (we) m[idx] = dat;
    reg_we = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] dat, input string tag);
    step(1'b1, idx, dat, 17'h0, 1'b0, tag);
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 4; s++) begin
      step(1'b0, 8'h0, 8'h0, 17'(s * 32'h8000 + 32'h123), 1'b0, tag);
      step(1'b0, 8'h0, 8'h0, 17'(s * 32'h8000 + 32'h4C0), 1'b1, tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] idx_list [8];
    idx_list = '{8'h04, 8'h18, 8'h19, 8'h1C, 8'h1D, 8'h1E, 8'h20, 8'h21};
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, direct path off
    sweep("R1");
    // R11: frame-buffer-only enables the direct address
    wreg(8'h21, 8'h01, "R11");
    sweep("R11");
    // R3: extended banking off ignores bases and dual bit
    wreg(8'h18, 8'h12, "R3");
    wreg(8'h19, 8'h34, "R3");
    wreg(8'h1E, 8'h04, "R3");
    step(1'b0, 8'h0, 8'h0, 17'h12345, 1'b0, "R3");
    sweep("R3");
    // R2: primary only
    wreg(8'h1E, 8'h10, "R2");
    sweep("R2");
    wreg(8'h1C, 8'h00, "R4");
    wreg(8'h1D, 8'h40, "R4");
    // R13: write and access in the same cycle sees old mapping
    step(1'b1, 8'h1E, 8'h74, 17'h08010, 1'b0, "R13");
    step(1'b0, 8'h0, 8'h0, 17'h08010, 1'b0, "R13");
    sweep("R6");
    wreg(8'h1E, 8'h14, "R4");
    sweep("R4");
    wreg(8'h1E, 8'h54, "R5");
    sweep("R5");
    wreg(8'h1E, 8'hD4, "R7");
    sweep("R7");
    // R9: wide offset mask
    wreg(8'h20, 8'h01, "R9");
    step(1'b0, 8'h0, 8'h0, 17'h1ABCD, 1'b0, "R9");
    step(1'b0, 8'h0, 8'h0, 17'h0FFFF, 1'b1, "R9");
    wreg(8'h20, 8'h00, "R9");
    step(1'b0, 8'h0, 8'h0, 17'h1ABCD, 1'b0, "R9");
    // R10: top of memory rejects, wrapped slot does not
    wreg(8'h1E, 8'h10, "R10");
    wreg(8'h18, 8'hFF, "R10");
    wreg(8'h19, 8'hFF, "R10");
    sweep("R10");
    wreg(8'h18, 8'h7F, "R10");
    step(1'b0, 8'h0, 8'h0, 17'h0003F, 1'b0, "R10");
    step(1'b0, 8'h0, 8'h0, 17'h00040, 1'b0, "R10");
    // R12: chain-4 flags
    wreg(8'h04, 8'h08, "R12");
    step(1'b0, 8'h0, 8'h0, 17'h0, 1'b0, "R12");
    wreg(8'h20, 8'h02, "R12");
    wreg(8'h04, 8'h00, "R12");
    step(1'b0, 8'h0, 8'h0, 17'h0, 1'b0, "R12");
    wreg(8'h20, 8'h00, "R12");
    // R8: unsupported mode falls back and latches error
    wreg(8'h18, 8'h01, "R8");
    wreg(8'h1E, 8'h34, "R8");
    sweep("R8");
    wreg(8'h1E, 8'h54, "R8");
    sweep("R8");
    // R11: direct path off again exposes planar base
    wreg(8'h21, 8'h00, "R11");
    sweep("R11");

    for (int n = 0; n < 4000; n++) begin
      bit we = ($urandom_range(0, 3) == 0);
      logic [7:0] idx = idx_list[$urandom_range(0, 7)];
      logic [7:0] dat = 8'($urandom);
      if (idx == 8'h21) dat[0] = ($urandom_range(0, 3) != 0);
      step(we, idx, dat, 17'($urandom), 1'($urandom), "R9");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule